// File: doc/BRIEF.md
# Quaternary Short Scrambling Sequence Generator

This block produces a complex short scrambling sequence for an uplink transmitter, at one chip per asserted chip enable. Three 8-stage feedback shift registers run in lockstep. Two of them are binary shift registers over GF(2), and the third holds symbols modulo 4. The output bit of each binary register is doubled and added, modulo 4, to the output symbol of the quaternary register. The result is a quaternary chip. A mapper turns that chip into a pair of sign bits that select one of four QPSK points.

A load strobe seeds all three registers from a 24-bit code number. Each group of 256 chips after a load holds one step: the registers advance 255 times and then stand still for one chip. This gives the output a period of exactly 256 chips. A small control state machine sequences the hold. It has two states. In `ST_RUN` each chip shifts the registers. In `ST_HOLD` the chip is emitted without a shift. There are three transitions:
- `T_ENTER_HOLD` moves from `ST_RUN` to `ST_HOLD` on the chip whose counter value is 254.
- `T_RESUME` moves from `ST_HOLD` back to `ST_RUN` on the next chip.
- `T_RESTART` moves from any state to `ST_RUN`, with the counter cleared, on reset or on load.

Top module: `qsc_gen`

## Requirements
- R1: Binary register A shifts toward stage 0. Stage 0 is its output, and each stage k takes stage k+1. The new stage 7 is the XOR of stages 0, 4, 5 and 7.
- R2: Binary register B shifts in the same way. Its new stage 7 is the XOR of stages 0, 1, 5 and 7.
- R3: The quaternary register shifts in the same way. Its new stage 7 is (3·s0 + 2·s1 + 3·s2 + 1·s3 + 3·s5) mod 4.
- R4: The chip value is `chip_z` = (2·A[0] + 2·B[0] + Q[0]) mod 4. It is taken from the state before that chip's shift.
- R5: The sign bits follow the chip value, where 0 means +1 and 1 means −1. For z=0 the pair (I, Q) is (0, 0). For z=1 it is (1, 0), for z=2 it is (1, 1), and for z=3 it is (0, 1).
- R6: Chips are numbered from 0 after each load, modulo 256. Chip 255 is followed by no shift, so the chip sequence repeats every 256 chips.
- R7: A load copies bit 16+k of `code` to stage k of register A, and bit 8+k to stage k of register B. A byte of zero loads the value 1 instead. Quaternary stage k receives 2·code[k]+1.
- R8: A load takes precedence over `chip_en` in the same cycle. Such a cycle neither shifts nor changes the outputs. The next enabled chip is computed from the freshly loaded state.
- R9: In a cycle with `chip_en` low, the outputs and the sequence position do not change.
- R10: Reset sets the outputs to zero and puts the registers in the state a load of code 0 gives. The first chip after reset is therefore z=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Seed all registers from `code` |
| code | input | 24 | Code number used on load |
| chip_en | input | 1 | Advance one chip |
| chip_z | output | 2 | Registered quaternary chip |
| chip_i | output | 1 | In-phase sign bit (1 = −1) |
| chip_q | output | 1 | Quadrature sign bit (1 = −1) |

## Verification
Two events can fall in the same cycle: a load and an enabled chip. A load can also arrive on the held chip at count 255. The bench raises `load` and `chip_en` together, once right after reset and once while the state machine sits in `ST_HOLD`. It judges that the outputs stay unchanged in that cycle, that the next enabled chip equals the value computed by hand from the code number, and that the 256-chip period restarts from the load. A behavioural model compares every cycle, and the periodicity is checked over three periods for four code numbers.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

    typedef logic [1:0] quat_t;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } qsc_state_e;

    function automatic logic sign_i(input quat_t z);
        return z[1] ^ z[0];
    endfunction

    function automatic logic sign_q(input quat_t z);
        return z[1];
    endfunction

endpackage

// File: rtl/qsc_ctrl.sv
module qsc_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic chip_en,
    output logic emit,
    output logic step
);
    import qsc_pkg::*;

    localparam logic [CNT_W-1:0] CNT_LAST = '1;
    localparam logic [CNT_W-1:0] CNT_PRE  = CNT_LAST - 1'b1;

    qsc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst || load) begin
            state_q <= ST_RUN;                       // T_RESTART
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (emit) begin
            unique case (state_q)
                ST_RUN:  if (cnt_q == CNT_PRE) state_d = ST_HOLD;  // T_ENTER_HOLD
                ST_HOLD: state_d = ST_RUN;                         // T_RESUME
                default: state_d = ST_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        emit = chip_en && !load;
        step = 1'b0;
        unique case (state_q)
            ST_RUN:  step = emit;
            ST_HOLD: step = 1'b0;
            default: step = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= '0;
        end else if (emit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_hold_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |-> (cnt_q == CNT_LAST));

    assert_load_restart_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == '0 && state_q == ST_RUN));

    assert_idle_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (!chip_en && !load) |=> ($stable(cnt_q) && $stable(state_q)));

endmodule

// File: rtl/qsc_bin_lfsr.sv
module qsc_bin_lfsr #(
    parameter int          STAGES = 8,
    parameter logic [STAGES-1:0] TAPS = 8'hB1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STAGES-1:0] seed,
    input  logic              step,
    output logic              bit_out
);
    localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};

    logic [STAGES-1:0] sr_q;
    logic              fb;

    assign fb      = ^(sr_q & TAPS);
    assign bit_out = sr_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= ONE;
        end else if (load) begin
            sr_q <= (seed == '0) ? ONE : seed;
        end else if (step) begin
            sr_q <= {fb, sr_q[STAGES-1:1]};
        end
    end

    assert_bin_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        sr_q != '0);

    assert_bin_shift_R1: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (sr_q[STAGES-2:0] == $past(sr_q[STAGES-1:1])));

    assert_bin_still_R6: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(sr_q));

endmodule

// File: rtl/qsc_quat_lfsr.sv
module qsc_quat_lfsr #(
    parameter int STAGES = 8,
    parameter logic [2*STAGES-1:0] COEF = 16'h0C7B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STAGES-1:0] seed,
    input  logic              step,
    output qsc_pkg::quat_t    sym_out
);
    import qsc_pkg::*;

    quat_t            sr_q [STAGES];
    quat_t            prod [STAGES];
    logic [STAGES-1:0] lsb;
    quat_t            fb;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_tap
            logic [3:0] wide;
            assign wide    = {2'b00, COEF[2*g +: 2]} * {2'b00, sr_q[g]};
            assign prod[g] = wide[1:0];
            assign lsb[g]  = sr_q[g][0];
        end
    endgenerate

    always_comb begin
        fb = '0;
        for (int k = 0; k < STAGES; k++) begin
            fb = fb + prod[k];
        end
    end

    assign sym_out = sr_q[0];

    always_ff @(posedge clk) begin
        for (int k = 0; k < STAGES; k++) begin
            if (rst) begin
                sr_q[k] <= 2'd1;
            end else if (load) begin
                sr_q[k] <= {seed[k], 1'b1};
            end else if (step) begin
                sr_q[k] <= (k == STAGES - 1) ? fb : sr_q[(k + 1) % STAGES];
            end
        end
    end

    assert_quat_odd_load_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (lsb == '1));

    assert_quat_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (sr_q[0] == $past(sr_q[1])));

endmodule

// File: rtl/qsc_mapper.sv
module qsc_mapper (
    input  logic           bit_a,
    input  logic           bit_b,
    input  qsc_pkg::quat_t sym_q,
    output qsc_pkg::quat_t z,
    output logic           s_i,
    output logic           s_q
);
    import qsc_pkg::*;

    always_comb begin
        z   = sym_q + {bit_a, 1'b0} + {bit_b, 1'b0};
        s_i = sign_i(z);
        s_q = sign_q(z);
    end

endmodule

// File: rtl/qsc_gen.sv
module qsc_gen #(
    parameter int CODE_W = 24,
    parameter int STAGES = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    input  logic              chip_en,
    output logic [1:0]        chip_z,
    output logic              chip_i,
    output logic              chip_q
);
    import qsc_pkg::*;

    localparam int A_LO = 2 * STAGES;
    localparam int B_LO = STAGES;

    logic  emit, step;
    logic  a_bit, b_bit;
    quat_t q_sym, z_d;
    logic  i_d, q_d;

    qsc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .load(load), .chip_en(chip_en),
        .emit(emit), .step(step)
    );

    qsc_bin_lfsr #(.STAGES(STAGES), .TAPS(8'hB1)) u_reg_a (
        .clk(clk), .rst(rst), .load(load),
        .seed(code[A_LO +: STAGES]), .step(step), .bit_out(a_bit)
    );

    qsc_bin_lfsr #(.STAGES(STAGES), .TAPS(8'hA3)) u_reg_b (
        .clk(clk), .rst(rst), .load(load),
        .seed(code[B_LO +: STAGES]), .step(step), .bit_out(b_bit)
    );

    qsc_quat_lfsr #(.STAGES(STAGES), .COEF(16'h0C7B)) u_reg_q (
        .clk(clk), .rst(rst), .load(load),
        .seed(code[0 +: STAGES]), .step(step), .sym_out(q_sym)
    );

    qsc_mapper u_map (
        .bit_a(a_bit), .bit_b(b_bit), .sym_q(q_sym),
        .z(z_d), .s_i(i_d), .s_q(q_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_z <= '0;
            chip_i <= 1'b0;
            chip_q <= 1'b0;
        end else if (emit) begin
            chip_z <= z_d;
            chip_i <= i_d;
            chip_q <= q_d;
        end
    end

    assert_map_levels_R5: assert property (@(posedge clk) disable iff (rst)
        (chip_i == (chip_z == 2'd1 || chip_z == 2'd2)) && (chip_q == (chip_z >= 2'd2)));

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> ($stable(chip_z) && $stable(chip_i) && $stable(chip_q)));

    assert_idle_outputs_R9: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> ($stable(chip_z) && $stable(chip_i) && $stable(chip_q)));

endmodule

// File: tb/qsc_gen_tb.sv
module qsc_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [23:0] code = '0;
    logic        chip_en = 1'b0;
    logic [1:0]  chip_z;
    logic        chip_i, chip_q;

    always #5 clk = ~clk;

    qsc_gen u_dut (
        .clk(clk), .rst(rst), .load(load), .code(code), .chip_en(chip_en),
        .chip_z(chip_z), .chip_i(chip_i), .chip_q(chip_q)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int m1[8], m2[8], mq[8];
    int mcnt;
    int ez, ei, eq;
    int seq[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_load(input logic [23:0] n);
        for (int k = 0; k < 8; k++) begin
            m1[k] = n[16+k];
            m2[k] = n[8+k];
            mq[k] = 2 * n[k] + 1;
        end
        if (n[23:16] == 8'h00) m1[0] = 1;
        if (n[15:8] == 8'h00) m2[0] = 1;
        mcnt = 0;
    endtask

    task automatic model_chip();
        int f1, f2, fq;
        ez = (2 * m1[0] + 2 * m2[0] + mq[0]) % 4;
        ei = (ez == 1 || ez == 2) ? 1 : 0;
        eq = (ez >= 2) ? 1 : 0;
        if (mcnt != 255) begin
            f1 = m1[0] ^ m1[4] ^ m1[5] ^ m1[7];
            f2 = m2[0] ^ m2[1] ^ m2[5] ^ m2[7];
            fq = (3 * mq[0] + 2 * mq[1] + 3 * mq[2] + mq[3] + 3 * mq[5]) % 4;
            for (int k = 0; k < 7; k++) begin
                m1[k] = m1[k+1];
                m2[k] = m2[k+1];
                mq[k] = mq[k+1];
            end
            m1[7] = f1;
            m2[7] = f2;
            mq[7] = fq;
        end
        mcnt = (mcnt + 1) % 256;
    endtask

    function automatic int first_chip(input logic [23:0] n);
        int a, b;
        a = (n[23:16] == 8'h00) ? 1 : int'(n[16]);
        b = (n[15:8] == 8'h00) ? 1 : int'(n[8]);
        return (2 * a + 2 * b + 2 * n[0] + 1) % 4;
    endfunction

    task automatic cycle(input bit l, input logic [23:0] n, input bit en, input bit rec);
        int pz;
        pz = int'({chip_z, chip_i, chip_q});
        @(negedge clk);
        load = l;
        code = n;
        chip_en = en;
        @(posedge clk);
        if (l) model_load(n);
        else if (en) model_chip();
        #1;
        check(int'(chip_z) == ez && int'(chip_i) == ei && int'(chip_q) == eq,
              "R1 R2 R3 R4 R5 chip vs model", int'(chip_z), ez);
        if (l || !en)
            check(int'({chip_z, chip_i, chip_q}) == pz, "R8 R9 outputs held",
                  int'({chip_z, chip_i, chip_q}), pz);
        if (rec && en && !l) seq.push_back(int'(chip_z));
    endtask

    task automatic period_check(input string name);
        int miss = 0, first = -1;
        for (int k = 0; k + 256 < seq.size(); k++) begin
            if (seq[k] != seq[k+256]) begin
                miss++;
                if (first < 0) first = k;
            end
        end
        check(miss == 0 && seq.size() >= 3 * 256 + 1, {"R6 period 256 ", name}, miss, 0);
        if (first >= 0)
            $display("  mismatch at chip %0d: %0d vs %0d", first, seq[first], seq[first+256]);
        seq.delete();
    endtask

    task automatic run_code(input logic [23:0] n, input string name, input bit with_en);
        cycle(1'b1, n, with_en, 1'b0);
        cycle(1'b0, n, 1'b1, 1'b1);
        check(int'(chip_z) == first_chip(n), "R7 first chip after load",
              int'(chip_z), first_chip(n));
        for (int k = 0; k < 900; k++)
            cycle(1'b0, n, (k % 7) != 3, 1'b1);
        period_check(name);
    endtask

    initial begin
        model_load(24'h0);
        ez = 0; ei = 0; eq = 0;
        repeat (3) @(posedge clk);
        #1;
        check(chip_z == 2'd0 && !chip_i && !chip_q, "R10 reset outputs",
              int'({chip_z, chip_i, chip_q}), 0);
        @(negedge clk);
        rst = 1'b0;

        // R10: first chip after reset behaves as code 0
        cycle(1'b0, 24'h0, 1'b1, 1'b0);
        check(int'(chip_z) == 1, "R10 first chip after reset", int'(chip_z), 1);
        for (int k = 0; k < 20; k++) cycle(1'b0, 24'h0, 1'b1, 1'b0);

        // R8: load and chip enable together
        run_code(24'hA5C37E, "code A5C37E", 1'b1);
        run_code(24'h000000, "code 000000", 1'b0);
        run_code(24'hFFFFFF, "code FFFFFF", 1'b1);

        // R8 R6: load arriving on the held chip (count 255)
        cycle(1'b1, 24'h5A3C96, 1'b0, 1'b0);
        for (int k = 0; k < 255; k++) cycle(1'b0, 24'h5A3C96, 1'b1, 1'b0);
        cycle(1'b1, 24'h13579B, 1'b1, 1'b0);
        cycle(1'b0, 24'h13579B, 1'b1, 1'b1);
        check(int'(chip_z) == first_chip(24'h13579B), "R8 load during hold",
              int'(chip_z), first_chip(24'h13579B));
        for (int k = 0; k < 800; k++) cycle(1'b0, 24'h13579B, 1'b1, 1'b1);
        period_check("code 13579B");

        // R9: long idle stretch
        for (int k = 0; k < 10; k++) cycle(1'b0, 24'hFFFFFF, 1'b0, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule